// File: doc/BRIEF.md
# Character display timing controller

This block generates the raster timing for a text display built from character cells. It runs on a character clock and counts three things: character positions along a scan line, scan lines within a character row, and character rows within a frame. After the last row the frame can be stretched by a few extra scan lines. From these counts it drives horizontal and vertical sync, a display-enable strobe, a 14-bit refresh-memory address for the character store and a 5-bit raster address for the glyph generator. It also drives a cursor strobe for one character cell over a programmable band of scan lines.

A host programs sixteen byte registers through a byte-wide port with two locations. One location takes a register index on write and returns a status byte on read. The other location writes or reads the indexed register. Two mode bits can delay display enable and the cursor, each by one character clock. This lets them line up with an external character-store and glyph pipeline.

Top module: `crt_timing_ctrl`

## Requirements
- R1: A write with `bus_port`=0 loads the register index. A write with `bus_port`=1 stores `bus_wdata` into the indexed register, keeping only its defined bits. The defined bits are: registers 0–3, 13 and 15 are 8 bits; registers 4, 6 and 7 are 7 bits; registers 5, 9, 10 and 11 are 5 bits; registers 12 and 14 are 6 bits; register 8 is 2 bits. A read with `bus_port`=1 returns the indexed register, or 0 for an index of 16 or more.
- R2: The character counter runs from 0 to register 0 and then restarts. `hsync` is high for character positions p with reg2 ≤ p < reg2 + reg3[3:0], and never past the end of the line.
- R3: A frame has reg4+1 rows of reg9+1 scan lines each, followed by reg5 adjust scan lines. `row_addr` gives the scan line within the row, and during the adjust lines it counts 0 to reg5−1.
- R4: `vsync` rises at the first character of scan line 0 of row reg7. It stays high for reg3[7:4] scan lines, where 0 means 16, and it may run on into the next frame.
- R5: Display enable is high only when the row is below reg6, the character position is below reg1 and the line is not an adjust line.
- R6: `mem_addr` equals start + row×reg1 + character position, taken modulo 2^14. Start is {reg12, reg13}. During the adjust lines the row is taken as reg4.
- R7: Cursor is high when display enable is high, `mem_addr` equals {reg14, reg15} and the raster line lies between reg10 and reg11 inclusive.
- R8: When reg8 bit 0 is set, `disp_en` is delayed by one character clock. When reg8 bit 1 is set, `cursor` is delayed by one character clock. Each bit acts independently.
- R9: A read with `bus_port`=0 returns the vertical-blank flag in bit 5 and zero in every other bit. The flag is 1 while the row is at or above reg6 or the line is an adjust line.
- R10: While reset is asserted, all registers and counters are zero. The outputs `hsync`, `vsync`, `disp_en`, `cursor`, `mem_addr` and `row_addr` are 0, and the status read shows vertical blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_port | input | 1 | 0 = index/status location, 1 = data location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Display enable, optionally delayed |
| cursor | output | 1 | Cursor strobe, optionally delayed |
| mem_addr | output | 14 | Refresh memory address |
| row_addr | output | 5 | Scan line within character row |

## Verification
The hardest states to reach are a vertical sync pulse that runs past the end of a frame, the adjust lines after the last row, and a refresh address that wraps at 2^14. None of them can be forced from the ports. The bench programs small geometries that contain each of these cases. It then waits for the second rising edge of vsync, which guarantees that a full frame restart has happened under the new settings. From there it sweeps every character clock of two whole frames and compares each output with a position computed arithmetically from the cycle count. It does the same comparison for the delayed display-enable and cursor.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int CH_W  = 8;
  localparam int ROW_W = 7;
  localparam int RAS_W = 5;
  localparam int MA_W  = 14;
  localparam int NREG  = 16;
  localparam int VB_BIT = 5;

  // Defined bits of each register; undefined bits store as zero.
  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      4, 6, 7:         return 8'h7F;
      5, 9, 10, 11:    return 8'h1F;
      12, 14:          return 8'h3F;
      8:               return 8'h03;
      default:         return 8'hFF;
    endcase
  endfunction

  // Half-open window [start, start+width).
  function automatic logic in_window(input int unsigned pos, input int unsigned start,
                                     input int unsigned width);
    return (pos >= start) && ((pos - start) < width);
  endfunction

  // Closed interval [lo, hi].
  function automatic logic in_range(input int unsigned v, input int unsigned lo,
                                    input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Vertical sync width in scan lines; code 0 stands for 16.
  function automatic logic [4:0] vs_width(input logic [3:0] code);
    return (code == 4'd0) ? 5'd16 : {1'b0, code};
  endfunction

  function automatic logic [7:0] status_byte(input logic vblank);
    logic [7:0] s;
    s = 8'h00;
    s[VB_BIT] = vblank;
    return s;
  endfunction
endpackage

// File: rtl/crt_regfile.sv
module crt_regfile
  import crt_pkg::*;
#(
  parameter int DW = 8,
  parameter int NR = NREG,
  parameter int IW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_cs,
  input  logic               bus_wr,
  input  logic               bus_port,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               vblank,
  output logic [DW-1:0]      bus_rdata,
  output logic [NR-1:0][DW-1:0] regs
);
  localparam int NW = $clog2(NR);

  logic [IW-1:0] idx_q;
  logic          wr_idx, wr_dat;

  assign wr_idx = bus_cs && bus_wr && !bus_port;
  assign wr_dat = bus_cs && bus_wr && bus_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (wr_idx) idx_q <= bus_wdata[IW-1:0];
  end

  for (genvar gi = 0; gi < NR; gi++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wr_dat && (idx_q == IW'(gi)))
        q <= bus_wdata & DW'(field_mask(gi));
    end
    assign regs[gi] = q;
  end

  always_comb begin
    if (!bus_port)
      bus_rdata = DW'(status_byte(vblank));
    else if (int'(idx_q) < NR)
      bus_rdata = regs[idx_q[NW-1:0]];
    else
      bus_rdata = '0;
  end
endmodule

// File: rtl/crt_hcount.sv
module crt_hcount
  import crt_pkg::*;
#(
  parameter int HW = CH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_total,
  input  logic [HW-1:0] h_spos,
  input  logic [3:0]    h_sw,
  output logic [HW-1:0] hcnt,
  output logic          line_end,
  output logic          hsync
);
  // >= keeps the counter bounded if the total shrinks mid-line.
  assign line_end = (hcnt >= h_total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hcnt <= '0;
    else if (line_end) hcnt <= '0;
    else               hcnt <= hcnt + 1'b1;
  end

  assign hsync = in_window(int'(hcnt), int'(h_spos), int'(h_sw));
endmodule

// File: rtl/crt_vcount.sv
module crt_vcount
  import crt_pkg::*;
#(
  parameter int RW = ROW_W,
  parameter int SW = RAS_W,
  parameter int AW = MA_W,
  parameter int HW = CH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic [RW-1:0] v_total,
  input  logic [SW-1:0] v_adj,
  input  logic [RW-1:0] v_spos,
  input  logic [SW-1:0] max_ras,
  input  logic [3:0]    v_sw,
  input  logic [HW-1:0] h_disp,
  input  logic [AW-1:0] start_addr,
  output logic [RW-1:0] vrow,
  output logic [SW-1:0] ras,
  output logic          in_adj,
  output logic [AW-1:0] row_base,
  output logic          vsync,
  output logic          frame_go
);
  logic [RW-1:0] n_row;
  logic [SW-1:0] n_ras;
  logic          n_adj;
  logic [AW-1:0] n_base;
  logic [4:0]    vs_cnt;
  logic          vs_hit;

  always_comb begin
    n_row    = vrow;
    n_ras    = ras;
    n_adj    = in_adj;
    n_base   = row_base;
    frame_go = 1'b0;
    if (in_adj) begin
      if (({1'b0, ras} + (SW+1)'(1)) >= {1'b0, v_adj}) frame_go = 1'b1;
      else                                              n_ras = ras + 1'b1;
    end else if (ras >= max_ras) begin
      if (vrow >= v_total) begin
        if (v_adj == '0) frame_go = 1'b1;
        else begin
          n_adj = 1'b1;
          n_ras = '0;
        end
      end else begin
        n_row  = vrow + 1'b1;
        n_ras  = '0;
        n_base = row_base + AW'(h_disp);
      end
    end else begin
      n_ras = ras + 1'b1;
    end
    if (frame_go) begin
      n_row  = '0;
      n_ras  = '0;
      n_adj  = 1'b0;
      n_base = start_addr;
    end
  end

  assign vs_hit = !n_adj && (n_row == v_spos) && (n_ras == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vrow     <= '0;
      ras      <= '0;
      in_adj   <= 1'b0;
      row_base <= '0;
      vs_cnt   <= '0;
    end else if (line_end) begin
      vrow     <= n_row;
      ras      <= n_ras;
      in_adj   <= n_adj;
      row_base <= n_base;
      if (vs_hit)              vs_cnt <= vs_width(v_sw);
      else if (vs_cnt != 5'd0) vs_cnt <= vs_cnt - 5'd1;
    end
  end

  assign vsync = (vs_cnt != 5'd0);
endmodule

// File: rtl/crt_timing_ctrl.sv
module crt_timing_ctrl
  import crt_pkg::*;
#(
  parameter int DW = 8,
  parameter int HW = CH_W,
  parameter int RW = ROW_W,
  parameter int SW = RAS_W,
  parameter int AW = MA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs,
  input  logic          bus_wr,
  input  logic          bus_port,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          hsync,
  output logic          vsync,
  output logic          disp_en,
  output logic          cursor,
  output logic [AW-1:0] mem_addr,
  output logic [SW-1:0] row_addr
);
  localparam int HIW = AW - DW;

  logic [NREG-1:0][DW-1:0] regs;
  logic [HW-1:0] hcnt;
  logic          line_end;
  logic [RW-1:0] vrow;
  logic [SW-1:0] ras;
  logic          in_adj;
  logic [AW-1:0] row_base;
  logic          frame_go;
  logic          vblank;
  logic          de_raw, cur_raw, de_q, cur_q;
  logic          de_skew, cur_skew;
  logic [AW-1:0] start_addr, cur_addr;
  logic          unused_bits;

  assign start_addr = {regs[12][HIW-1:0], regs[13]};
  assign cur_addr   = {regs[14][HIW-1:0], regs[15]};
  assign de_skew    = regs[8][0];
  assign cur_skew   = regs[8][1];
  assign unused_bits = ^{regs[12][DW-1:HIW], regs[14][DW-1:HIW], regs[8][DW-1:2],
                         regs[4][DW-1:RW], regs[6][DW-1:RW], regs[7][DW-1:RW],
                         regs[5][DW-1:SW], regs[9][DW-1:SW], regs[10][DW-1:SW],
                         regs[11][DW-1:SW]};

  crt_regfile #(.DW(DW), .NR(NREG), .IW(5)) u_regs (
    .clk, .rst_n, .bus_cs, .bus_wr, .bus_port, .bus_wdata,
    .vblank(vblank), .bus_rdata, .regs(regs)
  );

  crt_hcount #(.HW(HW)) u_h (
    .clk, .rst_n,
    .h_total(regs[0]), .h_spos(regs[2]), .h_sw(regs[3][3:0]),
    .hcnt(hcnt), .line_end(line_end), .hsync(hsync)
  );

  crt_vcount #(.RW(RW), .SW(SW), .AW(AW), .HW(HW)) u_v (
    .clk, .rst_n, .line_end(line_end),
    .v_total(regs[4][RW-1:0]), .v_adj(regs[5][SW-1:0]),
    .v_spos(regs[7][RW-1:0]), .max_ras(regs[9][SW-1:0]),
    .v_sw(regs[3][7:4]), .h_disp(regs[1]), .start_addr(start_addr),
    .vrow(vrow), .ras(ras), .in_adj(in_adj), .row_base(row_base),
    .vsync(vsync), .frame_go(frame_go)
  );

  assign vblank   = in_adj || (vrow >= regs[6][RW-1:0]);
  assign de_raw   = !vblank && (hcnt < regs[1]);
  assign mem_addr = row_base + AW'(hcnt);
  assign row_addr = ras;
  assign cur_raw  = de_raw && (mem_addr == cur_addr) &&
                    in_range(int'(ras), int'(regs[10][SW-1:0]), int'(regs[11][SW-1:0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q  <= 1'b0;
      cur_q <= 1'b0;
    end else begin
      de_q  <= de_raw;
      cur_q <= cur_raw;
    end
  end

  assign disp_en = de_skew  ? de_q  : de_raw;
  assign cursor  = cur_skew ? cur_q : cur_raw;
endmodule

// File: rtl/crt_timing_ctrl_chk.sv
module crt_timing_ctrl_chk #(
  parameter int HW = 8,
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vsync,
  input logic          disp_en,
  input logic          cursor,
  input logic [AW-1:0] mem_addr,
  input logic [HW-1:0] hcnt,
  input logic          line_end,
  input logic          de_raw,
  input logic          cur_raw,
  input logic          vblank,
  input logic          in_adj,
  input logic          de_skew,
  input logic          cur_skew
);
  assert_line_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hcnt == '0));

  assert_vsync_line_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vsync));

  assert_de_outside_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> !vblank);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (de_raw && !line_end) |=> (mem_addr == $past(mem_addr) + AW'(1)));

  assert_cursor_in_display_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_raw |-> de_raw);

  assert_de_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (de_skew && $past(de_skew)) |-> (disp_en == $past(de_raw)));

  assert_cursor_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_skew && $past(cur_skew)) |-> (cursor == $past(cur_raw)));

  assert_adjust_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_adj |-> vblank);
endmodule

bind crt_timing_ctrl crt_timing_ctrl_chk #(.HW(HW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync(vsync), .disp_en(disp_en), .cursor(cursor),
  .mem_addr(mem_addr), .hcnt(hcnt), .line_end(line_end), .de_raw(de_raw),
  .cur_raw(cur_raw), .vblank(vblank), .in_adj(in_adj), .de_skew(de_skew),
  .cur_skew(cur_skew)
);

// File: tb/crt_timing_ctrl_tb.sv
`timescale 1ns/1ps
module crt_timing_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs = 1'b0, bus_wr = 1'b0, bus_port = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       hsync, vsync, disp_en, cursor;
  logic [13:0] mem_addr;
  logic [4:0]  row_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int cfg[16];

  always #2.5 clk = ~clk;

  crt_timing_ctrl u_dut (
    .clk, .rst_n, .bus_cs, .bus_wr, .bus_port, .bus_wdata, .bus_rdata,
    .hsync, .vsync, .disp_en, .cursor, .mem_addr, .row_addr
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int idx, input int val);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_port = 0; bus_wdata = 8'(idx);
    @(negedge clk);
    bus_port = 1; bus_wdata = 8'(val);
    @(negedge clk);
    bus_cs = 0; bus_wr = 0; bus_port = 0;
  endtask

  task automatic bus_read(input int idx, output int val);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_port = 0; bus_wdata = 8'(idx);
    @(negedge clk);
    bus_wr = 0; bus_port = 1;
    #1 val = int'(bus_rdata);
    bus_cs = 0; bus_port = 0;
  endtask

  task automatic program_all();
    for (int i = 0; i < 16; i++) bus_write(i, cfg[i]);
  endtask

  // Arithmetic model of position p (character clocks from frame start).
  task automatic model(input int p, output int hs, output int vs, output int de,
                       output int ma, output int ra, output int cur, output int vb);
    int l, lpr, nr, f, v0, g, h, row, adj, hw, vw, st, ca;
    l = cfg[0] + 1; lpr = cfg[9] + 1; nr = cfg[4] + 1;
    f = nr * lpr + cfg[5]; v0 = cfg[7] * lpr;
    g = p / l; h = p % l;
    if (g < nr * lpr) begin row = g / lpr; ra = g % lpr; adj = 0; end
    else begin row = cfg[4]; ra = g - nr * lpr; adj = 1; end
    hw = cfg[3] & 15;
    vw = ((cfg[3] >> 4) == 0) ? 16 : (cfg[3] >> 4);
    st = ((cfg[12] & 63) << 8) | cfg[13];
    ca = ((cfg[14] & 63) << 8) | cfg[15];
    hs = (h >= cfg[2] && (h - cfg[2]) < hw) ? 1 : 0;
    vs = (((g - v0 + f) % f) < vw) ? 1 : 0;
    vb = (adj == 1 || row >= cfg[6]) ? 1 : 0;
    de = (vb == 0 && h < cfg[1]) ? 1 : 0;
    ma = (st + row * cfg[1] + h) & 16'h3FFF;
    cur = (de == 1 && ma == ca && ra >= cfg[10] && ra <= cfg[11]) ? 1 : 0;
  endtask

  task automatic run_frames(input string tag);
    int l, f, fl, v0, rises;
    int hs, vs, de, ma, ra, cur, vb, hs2, vs2, de2, ma2, ra2, cur2, vb2;
    l = cfg[0] + 1;
    f = (cfg[4] + 1) * (cfg[9] + 1) + cfg[5];
    fl = f * l;
    v0 = cfg[7] * (cfg[9] + 1);
    @(negedge clk);
    bus_cs = 1; bus_wr = 0; bus_port = 0;
    rises = 0;
    while (rises < 2) begin
      while (vsync !== 1'b0) @(negedge clk);
      while (vsync !== 1'b1) @(negedge clk);
      rises++;
      if (rises < 2) @(negedge clk);
    end
    for (int k = 0; k < 2 * fl; k++) begin
      int p, pd;
      p = (v0 * l + k) % fl;
      pd = (p + fl - 1) % fl;
      model(p, hs, vs, de, ma, ra, cur, vb);
      model(pd, hs2, vs2, de2, ma2, ra2, cur2, vb2);
      if ((cfg[8] & 1) != 0) de = de2;
      if ((cfg[8] & 2) != 0) cur = cur2;
      chk(int'(hsync) == hs, "R2", {tag, " hsync"}, int'(hsync), hs);
      chk(int'(vsync) == vs, "R4", {tag, " vsync"}, int'(vsync), vs);
      chk(int'(row_addr) == ra, "R3", {tag, " row_addr"}, int'(row_addr), ra);
      chk(int'(disp_en) == de, ((cfg[8] & 1) != 0) ? "R8" : "R5", {tag, " disp_en"},
          int'(disp_en), de);
      chk(int'(mem_addr) == ma, "R6", {tag, " mem_addr"}, int'(mem_addr), ma);
      chk(int'(cursor) == cur, ((cfg[8] & 2) != 0) ? "R8" : "R7", {tag, " cursor"},
          int'(cursor), cur);
      chk(int'(bus_rdata) == (vb << 5), "R9", {tag, " status"}, int'(bus_rdata), vb << 5);
      @(negedge clk);
    end
    bus_cs = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(hsync == 1'b0, "R10", "hsync", int'(hsync), 0);
    chk(vsync == 1'b0, "R10", "vsync", int'(vsync), 0);
    chk(disp_en == 1'b0, "R10", "disp_en", int'(disp_en), 0);
    chk(cursor == 1'b0, "R10", "cursor", int'(cursor), 0);
    chk(mem_addr == 14'd0, "R10", "mem_addr", int'(mem_addr), 0);
    chk(row_addr == 5'd0, "R10", "row_addr", int'(row_addr), 0);
    bus_cs = 1; bus_wr = 0; bus_port = 0;
    #1 chk(bus_rdata == 8'h20, "R10", "status", int'(bus_rdata), 32'h20);
    bus_cs = 0;
    @(negedge clk) rst_n = 1'b1;

    // R1: field masks and readback
    bus_write(4, 8'hFF);  bus_read(4, v);  chk(v == 8'h7F, "R1", "reg4", v, 8'h7F);
    bus_write(12, 8'hFF); bus_read(12, v); chk(v == 8'h3F, "R1", "reg12", v, 8'h3F);
    bus_write(10, 8'hFF); bus_read(10, v); chk(v == 8'h1F, "R1", "reg10", v, 8'h1F);
    bus_write(8, 8'hFF);  bus_read(8, v);  chk(v == 8'h03, "R1", "reg8", v, 8'h03);
    bus_write(0, 8'hA5);  bus_read(0, v);  chk(v == 8'hA5, "R1", "reg0", v, 8'hA5);
    bus_write(17, 8'h55); bus_read(17, v); chk(v == 0, "R1", "index17", v, 0);

    // Config A: adjust lines, 14-bit address wrap, cursor band
    cfg = '{9, 6, 7, 8'h32, 4, 2, 3, 3, 0, 2, 1, 2, 8'h3F, 8'hFA, 8'h00, 8'h02};
    program_all();
    run_frames("cfgA");

    // Config B: vsync width code 0 (16 lines) spanning frame end, both delays
    cfg = '{5, 4, 4, 8'h03, 6, 0, 5, 5, 3, 3, 0, 3, 8'h01, 8'h00, 8'h01, 8'h05};
    program_all();
    run_frames("cfgB");

    // Config C: one line per row, displayed width beyond line total, cursor delay only
    cfg = '{7, 8, 0, 8'h11, 3, 3, 4, 2, 2, 0, 0, 0, 8'h00, 8'h10, 8'h00, 8'h25};
    program_all();
    run_frames("cfgC");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule